// File: doc/BRIEF.md
# SDRAM Chip-Select Window Decoder

This block holds a small table of programmable windows, one per SDRAM chip select, and maps each physical address presented on its lookup port to the chip select that owns it. For each lookup it reports the chip-select number and an active-low select vector that a downstream interconnect attaches to the request. If no window claims the address, a miss flag is raised. Software programs the windows through a simple word-addressed register port. A combinational count output shows how many chip selects can be reached by bus masters that drive only 32 address bits.

A parameter chooses between two register layouts. The default quad layout has four windows, each with a base word and a size word. The size is held as a mask whose low 24 bits are implied ones, and the size word also holds the reported chip-select number. The compact pair layout has two windows and one word per window. In that word a power-of-two size code, the base and the enable bit share the register, and the select vector is always zero because the memory controller selects the chip internally.

A lookup is accepted on any cycle. Its result is registered and appears exactly one cycle later.

Top module: `sdcs_window_decoder`

## Requirements
- R1: After reset every register reads as zero, every window is disabled, `usable_cnt` is 0, `res_valid` is low, and any lookup misses.
- R2: In the quad layout, the base word of window n is at byte offset 8n and its size word is at 8n+4, for n = 0..3. A mapped word reads back exactly what was last written to it. An offset that is not word-aligned, or that is 0x20 or above, reads as zero, and a write to such an offset changes no register.
- R3: In the quad layout, window n starts at the 36-bit address {base[3:0], base[31:24], 24'h0}. It covers every address from that start up to and including start + {size[31:24], 24'hFFFFFF}. Size bit 0 enables the window.
- R4: In the quad layout, a hit on window n reports `res_cs` equal to bits 4:2 of that window's size word.
- R5: In the quad layout, a hit on window n gives `res_attr[3:0]` = 4'hF with bit n cleared. `res_attr[4]` equals the value of `coh_en` in the lookup cycle.
- R6: When several enabled windows contain the address, the window with the lowest index wins.
- R7: When no enabled window contains the address, `res_miss` is 1 and both `res_cs` and `res_attr` are zero.
- R8: `usable_cnt` counts the windows that are enabled and whose start address has bits 35:32 all zero. In the pair layout this is every enabled window.
- R9: In the pair layout, the word for window n is at offset 16n, for n = 0..1, and every other offset is unmapped as in R2. Bit 0 is the enable. The window starts at {4'h0, word[31:23], 23'h0} and spans 2^(16+word[19:16]) bytes, which is 1 MiB shifted by (code − 4). A hit reports `res_cs` = n and `res_attr` = 0 whatever `coh_en` is.
- R10: Each cycle with `lk_valid` high produces exactly one `res_valid` pulse in the following cycle. The result outputs hold their values when no lookup is made.
- R11: A disabled window never hits, even for an address inside its programmed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to decode |
| coh_en | input | 1 | Coherent access flag, merged into the select vector |
| res_valid | output | 1 | Result valid, one cycle after the lookup |
| res_miss | output | 1 | No window matched |
| res_cs | output | 3 | Chip-select number of the winning window |
| res_attr | output | 5 | Active-low select vector plus coherency bit |
| usable_cnt | output | 3 | Number of usable chip selects |

## Verification
The assertions assume that reset is held for at least one clock before use. They also assume that `coh_en` is valid in every cycle where `lk_valid` is high, because the coherency bit is captured together with the address. The range checks assume that no window is programmed so that its end runs past the 36-bit address space. The stimulus keeps every programmed window inside that space. It changes register contents only in cycles without a lookup, so each expected result depends only on settled register values.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

    // Physical address width decoded by the block.
    localparam int ADDR_W = 36;
    // Register word width.
    localparam int REG_W  = 32;
    // Width of the reported chip-select number.
    localparam int CS_W   = 3;
    // Width of the select vector; the top bit is the coherency bit.
    localparam int ATTR_W = 5;
    // Largest window count over both layouts.
    localparam int MAX_WIN = 4;
    // Width of the usable-window count.
    localparam int CNT_W  = $clog2(MAX_WIN + 1);

    typedef enum logic {
        LAYOUT_QUAD = 1'b0,
        LAYOUT_PAIR = 1'b1
    } layout_e;

    // One decoded window.
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [CS_W-1:0]   cs;
        logic [3:0]        sel_n;
        logic              coh_ok;
        logic              usable;
    } win_desc_t;

    // Result of one lookup.
    typedef struct packed {
        logic              miss;
        logic [CS_W-1:0]   cs;
        logic [ATTR_W-1:0] attr;
    } dec_result_t;

    function automatic int num_windows(layout_e lay);
        return (lay == LAYOUT_QUAD) ? 4 : 2;
    endfunction

    function automatic int regs_per_window(layout_e lay);
        return (lay == LAYOUT_QUAD) ? 2 : 1;
    endfunction

    function automatic int stride_log2(layout_e lay);
        return (lay == LAYOUT_QUAD) ? 3 : 4;
    endfunction

    // Quad layout: a base word and a size word per window.
    function automatic win_desc_t quad_desc(logic [REG_W-1:0] bword,
                                            logic [REG_W-1:0] sword,
                                            int idx);
        win_desc_t d;
        d.en     = sword[0];
        d.base   = {bword[3:0], bword[31:24], 24'h00_0000};
        d.mask   = {4'h0, sword[31:24], 24'hFF_FFFF};
        d.cs     = sword[4:2];
        d.sel_n  = 4'hF & ~(4'h1 << idx);
        d.coh_ok = 1'b1;
        d.usable = sword[0] && (bword[3:0] == 4'h0);
        return d;
    endfunction

    // Pair layout: base, size code and enable share one word.
    function automatic win_desc_t pair_desc(logic [REG_W-1:0] word, int idx);
        win_desc_t d;
        logic [4:0] lg;
        lg       = 5'd16 + {1'b0, word[19:16]};
        d.en     = word[0];
        d.base   = {4'h0, word[31:23], 23'h0};
        d.mask   = ({{(ADDR_W-1){1'b0}}, 1'b1} << lg) - {{(ADDR_W-1){1'b0}}, 1'b1};
        d.cs     = CS_W'(idx);
        d.sel_n  = 4'h0;
        d.coh_ok = 1'b0;
        d.usable = word[0];
        return d;
    endfunction

endpackage

// File: rtl/sdcs_regfile.sv
module sdcs_regfile
    import sdcs_pkg::*;
#(
    parameter layout_e LAYOUT   = LAYOUT_QUAD,
    parameter int      REG_AW   = 8,
    localparam int     NUM_WIN  = num_windows(LAYOUT),
    localparam int     NUM_REGS = NUM_WIN * regs_per_window(LAYOUT)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [REG_AW-1:0]             addr,
    input  logic [REG_W-1:0]              wdata,
    output logic [REG_W-1:0]              rdata,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs_o
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int SLG   = stride_log2(LAYOUT);
    // Bits that must be zero inside one window stride.
    localparam logic [REG_AW-1:0] OFF_MASK =
        (LAYOUT == LAYOUT_QUAD) ? REG_AW'(3) : REG_AW'(15);

    logic [REG_AW-1:0] win_sel;
    logic [REG_AW-1:0] flat_idx;
    logic              mapped;
    logic [IDX_W-1:0]  idx;
    logic [REG_W-1:0]  regs_q [NUM_REGS];

    always_comb begin
        win_sel = addr >> SLG;
        if (LAYOUT == LAYOUT_QUAD) begin
            flat_idx = (win_sel << 1) | REG_AW'(addr[2]);
        end else begin
            flat_idx = win_sel;
        end
        mapped = ((addr & OFF_MASK) == '0) && (win_sel < REG_AW'(NUM_WIN));
        idx    = IDX_W'(flat_idx);
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[r] <= '0;
            end else if (we && mapped && (idx == IDX_W'(r))) begin
                regs_q[r] <= wdata;
            end
        end
        assign regs_o[r] = regs_q[r];
    end

    assign rdata = mapped ? regs_q[idx] : '0;

endmodule

// File: rtl/sdcs_desc_gen.sv
module sdcs_desc_gen
    import sdcs_pkg::*;
#(
    parameter layout_e LAYOUT   = LAYOUT_QUAD,
    localparam int     NUM_WIN  = num_windows(LAYOUT),
    localparam int     NUM_REGS = NUM_WIN * regs_per_window(LAYOUT)
) (
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs_i,
    output win_desc_t [NUM_WIN-1:0]        desc_o,
    output logic [CNT_W-1:0]               usable_cnt
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        if (LAYOUT == LAYOUT_QUAD) begin : g_quad
            assign desc_o[w] = quad_desc(regs_i[2*w], regs_i[2*w+1], w);
        end else begin : g_pair
            assign desc_o[w] = pair_desc(regs_i[w], w);
        end
    end

    always_comb begin
        usable_cnt = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            usable_cnt = usable_cnt + CNT_W'(desc_o[w].usable);
        end
    end

endmodule

// File: rtl/sdcs_win_match.sv
module sdcs_win_match
    import sdcs_pkg::*;
(
    input  win_desc_t         desc,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    // A one-bit-wider subtraction gives the offset and the below-base flag together.
    logic [ADDR_W:0] offset;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, desc.base};
        hit    = desc.en && !offset[ADDR_W] && (offset[ADDR_W-1:0] <= desc.mask);
    end

endmodule

// File: rtl/sdcs_prio_sel.sv
module sdcs_prio_sel
    import sdcs_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  win_desc_t [NUM_WIN-1:0] desc,
    input  logic [NUM_WIN-1:0]      hits,
    input  logic                    coh_en,
    output dec_result_t             result
);

    logic found;

    always_comb begin
        found  = 1'b0;
        result = '{miss: 1'b1, cs: '0, attr: '0};
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hits[w] && !found) begin
                found       = 1'b1;
                result.miss = 1'b0;
                result.cs   = desc[w].cs;
                result.attr = {coh_en & desc[w].coh_ok, desc[w].sel_n};
            end
        end
    end

endmodule

// File: rtl/sdcs_window_decoder.sv
module sdcs_window_decoder
    import sdcs_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_QUAD,
    parameter int      REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [35:0]       lk_addr,
    input  logic              coh_en,
    output logic              res_valid,
    output logic              res_miss,
    output logic [2:0]        res_cs,
    output logic [4:0]        res_attr,
    output logic [2:0]        usable_cnt
);

    localparam int NUM_WIN  = num_windows(LAYOUT);
    localparam int NUM_REGS = NUM_WIN * regs_per_window(LAYOUT);

    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    win_desc_t [NUM_WIN-1:0]        desc;
    logic [NUM_WIN-1:0]             hits;
    dec_result_t                    pick;
    dec_result_t                    res_q;
    logic                           valid_q;

    sdcs_regfile #(.LAYOUT(LAYOUT), .REG_AW(REG_AW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .regs_o (regs)
    );

    sdcs_desc_gen #(.LAYOUT(LAYOUT)) u_desc (
        .regs_i     (regs),
        .desc_o     (desc),
        .usable_cnt (usable_cnt)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        sdcs_win_match u_match (
            .desc (desc[w]),
            .addr (lk_addr),
            .hit  (hits[w])
        );
    end

    sdcs_prio_sel #(.NUM_WIN(NUM_WIN)) u_sel (
        .desc   (desc),
        .hits   (hits),
        .coh_en (coh_en),
        .result (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= lk_valid;
            if (lk_valid) begin
                res_q <= pick;
            end
        end
    end

    assign res_valid = valid_q;
    assign res_miss  = res_q.miss;
    assign res_cs    = res_q.cs;
    assign res_attr  = res_q.attr;

endmodule

// File: rtl/sdcs_window_decoder_chk.sv
module sdcs_window_decoder_chk
    import sdcs_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_QUAD
) (
    input logic       clk,
    input logic       rst,
    input logic       lk_valid,
    input logic       coh_en,
    input logic       res_valid,
    input logic       res_miss,
    input logic [2:0] res_cs,
    input logic [4:0] res_attr,
    input logic [2:0] usable_cnt
);

    localparam int NUM_WIN = num_windows(LAYOUT);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && usable_cnt == 3'd0)); // R1

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid); // R10

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!res_valid && $stable(res_cs) && $stable(res_attr) && $stable(res_miss))); // R10

    AST_MISS_BLANK: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_miss) |-> (res_cs == 3'd0 && res_attr == 5'd0)); // R7

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        usable_cnt <= 3'(NUM_WIN)); // R8

    if (LAYOUT == LAYOUT_QUAD) begin : g_quad
        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            (res_valid && !res_miss) |-> ($countones(~res_attr[3:0]) == 1)); // R5

        AST_COH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            lk_valid |=> (res_miss || res_attr[4] == $past(coh_en))); // R5
    end else begin : g_pair
        AST_PAIR_ATTR: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> (res_attr == 5'd0)); // R9

        AST_PAIR_CS: assert property (@(posedge clk) disable iff (rst)
            (res_valid && !res_miss) |-> (res_cs < 3'd2)); // R9
    end

endmodule

bind sdcs_window_decoder sdcs_window_decoder_chk #(.LAYOUT(LAYOUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .coh_en     (coh_en),
    .res_valid  (res_valid),
    .res_miss   (res_miss),
    .res_cs     (res_cs),
    .res_attr   (res_attr),
    .usable_cnt (usable_cnt)
);

// File: tb/sdcs_window_decoder_tb_top.sv
`timescale 1ns/1ps
module sdcs_window_decoder_tb_top;
    import sdcs_pkg::*;

    typedef struct {
        logic       miss;
        logic [2:0] cs;
        logic [4:0] attr;
        logic [35:0] addr;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Quad-layout instance signals
    logic        q_we = 0;
    logic [7:0]  q_addr = 0;
    logic [31:0] q_wdata = 0, q_rdata;
    logic        q_lk_valid = 0;
    logic [35:0] q_lk_addr = 0;
    logic        q_coh = 0;
    logic        q_res_valid, q_res_miss;
    logic [2:0]  q_res_cs, q_cnt;
    logic [4:0]  q_res_attr;

    // Pair-layout instance signals
    logic        p_we = 0;
    logic [7:0]  p_addr = 0;
    logic [31:0] p_wdata = 0, p_rdata;
    logic        p_lk_valid = 0;
    logic [35:0] p_lk_addr = 0;
    logic        p_coh = 0;
    logic        p_res_valid, p_res_miss;
    logic [2:0]  p_res_cs, p_cnt;
    logic [4:0]  p_res_attr;

    sdcs_window_decoder #(.LAYOUT(LAYOUT_QUAD)) dut_i (
        .clk(clk), .rst(rst), .reg_we(q_we), .reg_addr(q_addr), .reg_wdata(q_wdata),
        .reg_rdata(q_rdata), .lk_valid(q_lk_valid), .lk_addr(q_lk_addr), .coh_en(q_coh),
        .res_valid(q_res_valid), .res_miss(q_res_miss), .res_cs(q_res_cs),
        .res_attr(q_res_attr), .usable_cnt(q_cnt)
    );

    sdcs_window_decoder #(.LAYOUT(LAYOUT_PAIR)) dut_pk_i (
        .clk(clk), .rst(rst), .reg_we(p_we), .reg_addr(p_addr), .reg_wdata(p_wdata),
        .reg_rdata(p_rdata), .lk_valid(p_lk_valid), .lk_addr(p_lk_addr), .coh_en(p_coh),
        .res_valid(p_res_valid), .res_miss(p_res_miss), .res_cs(p_res_cs),
        .res_attr(p_res_attr), .usable_cnt(p_cnt)
    );

    // Bench copies of what was written, kept from the register map in R2/R9
    logic [31:0] sh_q [8];
    logic [31:0] sh_p [2];
    exp_t  exp_q [$];
    exp_t  exp_p [$];
    string tag_q [$];
    string tag_p [$];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    // Expected result in the quad layout (R3..R7, R11)
    function automatic exp_t model_quad(logic [35:0] a, logic coh);
        exp_t e;
        logic [35:0] b, lim;
        e.miss = 1'b1; e.cs = '0; e.attr = '0; e.addr = a;
        for (int w = 3; w >= 0; w--) begin
            b   = {sh_q[2*w][3:0], sh_q[2*w][31:24], 24'h0};
            lim = b + {4'h0, sh_q[2*w+1][31:24], 24'hFF_FFFF};
            if (sh_q[2*w+1][0] && a >= b && a <= lim) begin
                e.miss = 1'b0;
                e.cs   = sh_q[2*w+1][4:2];
                e.attr = {coh, 4'hF & ~(4'h1 << w)};
            end
        end
        return e;
    endfunction

    // Expected result in the pair layout (R9)
    function automatic exp_t model_pair(logic [35:0] a);
        exp_t e;
        logic [35:0] b, sz;
        e.miss = 1'b1; e.cs = '0; e.attr = '0; e.addr = a;
        for (int w = 1; w >= 0; w--) begin
            b  = {4'h0, sh_p[w][31:23], 23'h0};
            sz = 36'h1 << (16 + int'(sh_p[w][19:16]));
            if (sh_p[w][0] && a >= b && (a - b) < sz) begin
                e.miss = 1'b0;
                e.cs   = 3'(w);
            end
        end
        return e;
    endfunction

    task automatic wr(input bit pk, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (pk) begin
            p_addr = a; p_wdata = d; p_we = 1'b1;
            if (a[3:0] == 4'h0 && a < 8'h20) sh_p[a[4]] = d;
        end else begin
            q_addr = a; q_wdata = d; q_we = 1'b1;
            if (a[1:0] == 2'b00 && a < 8'h20) sh_q[a[4:2]] = d;
        end
        @(negedge clk);
        p_we = 1'b0; q_we = 1'b0;
    endtask

    task automatic rd_chk(input bit pk, input logic [7:0] a, input logic [31:0] expv,
                          input string rq);
        logic [31:0] got;
        @(negedge clk);
        if (pk) p_addr = a; else q_addr = a;
        #1;
        got = pk ? p_rdata : q_rdata;
        check(got === expv, rq, $sformatf("read offset %0h", a), 64'(got), 64'(expv));
    endtask

    task automatic look(input bit pk, input logic [35:0] a, input string rq);
        @(negedge clk);
        if (pk) begin
            exp_p.push_back(model_pair(a)); tag_p.push_back(rq);
            p_lk_addr = a; p_lk_valid = 1'b1;
        end else begin
            exp_q.push_back(model_quad(a, q_coh)); tag_q.push_back(rq);
            q_lk_addr = a; q_lk_valid = 1'b1;
        end
        @(negedge clk);
        p_lk_valid = 1'b0; q_lk_valid = 1'b0;
    endtask

    task automatic cmp(input exp_t e, input string rq, input logic miss,
                       input logic [2:0] cs, input logic [4:0] attr);
        check(miss === e.miss && cs === e.cs && attr === e.attr, rq,
              $sformatf("lookup %0h {miss,cs,attr}", e.addr),
              64'({miss, cs, attr}), 64'({e.miss, e.cs, e.attr}));
    endtask

    // Monitors: pop and compare each result as it appears (R10 pairing)
    always @(negedge clk) begin
        if (!rst && q_res_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R10", "quad unexpected result", 64'd1, 64'd0);
            else cmp(exp_q.pop_front(), tag_q.pop_front(), q_res_miss, q_res_cs, q_res_attr);
        end
        if (!rst && p_res_valid) begin
            if (exp_p.size() == 0) check(1'b0, "R10", "pair unexpected result", 64'd1, 64'd0);
            else cmp(exp_p.pop_front(), tag_p.pop_front(), p_res_miss, p_res_cs, p_res_attr);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) sh_q[i] = '0;
        for (int i = 0; i < 2; i++) sh_p[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk(0, 8'h04, 32'h0, "R1");
        rd_chk(1, 8'h00, 32'h0, "R1");
        check(q_cnt === 3'd0, "R1", "quad usable count", 64'(q_cnt), 64'd0);
        check(p_cnt === 3'd0, "R1", "pair usable count", 64'(p_cnt), 64'd0);
        look(0, 36'h0_0000_0000, "R1");
        look(1, 36'h0_0080_0000, "R1");

        // Quad layout programming (R2)
        wr(0, 8'h00, 32'h0000_0000); wr(0, 8'h04, 32'h0F00_000D); // cs field 3
        wr(0, 8'h08, 32'h1000_0000); wr(0, 8'h0C, 32'h0000_0015); // cs field 5
        wr(0, 8'h10, 32'h0800_0000); wr(0, 8'h14, 32'h0100_0005); // cs field 1
        wr(0, 8'h18, 32'h2000_0001); wr(0, 8'h1C, 32'h0000_001D); // high base
        wr(0, 8'h20, 32'hFFFF_FFFF);   // unmapped: ignored
        wr(0, 8'h06, 32'hFFFF_FFFF);   // misaligned: ignored
        rd_chk(0, 8'h04, 32'h0F00_000D, "R2");
        rd_chk(0, 8'h18, 32'h2000_0001, "R2");
        rd_chk(0, 8'h1C, 32'h0000_001D, "R2");
        rd_chk(0, 8'h20, 32'h0, "R2");
        rd_chk(0, 8'h06, 32'h0, "R2");

        // R8: window 3 is enabled but starts above 32 bits
        #1 check(q_cnt === 3'd3, "R8", "quad usable count", 64'(q_cnt), 64'd3);

        // Decode
        look(0, 36'h0_0000_0000, "R3");
        look(0, 36'h0_0FFF_FFFF, "R3");
        look(0, 36'h0_1000_0000, "R4");
        look(0, 36'h0_10FF_FFFF, "R4");
        look(0, 36'h0_1100_0000, "R7");
        look(0, 36'h0_2000_0000, "R7");
        look(0, 36'h1_2000_0010, "R5");
        look(0, 36'h0_0900_0000, "R6");
        q_coh = 1'b1;
        look(0, 36'h0_1000_0000, "R5");
        look(0, 36'h1_20FF_FFFF, "R5");
        q_coh = 1'b0;
        look(0, 36'h1_2100_0000, "R7");

        // Disable window 0 (R11): its range now falls through to window 2 or misses
        wr(0, 8'h04, 32'h0F00_000C);
        look(0, 36'h0_0000_0000, "R11");
        look(0, 36'h0_0800_0000, "R6");
        look(0, 36'h0_0A00_0000, "R11");
        #1 check(q_cnt === 3'd2, "R8", "quad usable after disable", 64'(q_cnt), 64'd2);

        // Pair layout (R9)
        wr(1, 8'h00, 32'h0084_0001);   // 1 MiB at 0x0080_0000
        wr(1, 8'h10, 32'h400E_0001);   // 1 GiB at 0x4000_0000
        wr(1, 8'h04, 32'hFFFF_FFFF);   // unmapped in this layout
        rd_chk(1, 8'h00, 32'h0084_0001, "R9");
        rd_chk(1, 8'h10, 32'h400E_0001, "R9");
        rd_chk(1, 8'h04, 32'h0, "R9");
        #1 check(p_cnt === 3'd2, "R8", "pair usable count", 64'(p_cnt), 64'd2);
        look(1, 36'h0_0080_0000, "R9");
        look(1, 36'h0_008F_FFFF, "R9");
        look(1, 36'h0_0090_0000, "R9");
        look(1, 36'h0_7FFF_FFFF, "R9");
        look(1, 36'h0_8000_0000, "R9");
        look(1, 36'h1_4000_0000, "R9");
        p_coh = 1'b1;
        look(1, 36'h0_4000_0000, "R9");
        p_coh = 1'b0;

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && exp_p.size() == 0, "R10", "pending results",
              64'(exp_q.size() + exp_p.size()), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule